// File: doc/BRIEF.md
# Highway and Side-Road Signal Controller

This block sequences two three-lamp signal heads at a crossing. One head faces a busy highway and the other a quiet side road. The highway holds the right of way by default. A car sensed on the side road, or a pedestrian wanting to cross the highway, can take that right of way away, but only after the highway has been green for a minimum interval. The side road then gets a green whose length depends on the sensor: it lasts at least the medium interval, and it is extended while cars keep arriving, up to the long interval.

All timing is built from a seconds tick. A clock-enable divider produces that tick, with TICK_DIV clocks per second. Three restartable interval timers count the tick: long (60 s), medium (30 s) and short (10 s). A timer output goes low when the controller restarts it. It goes high after its programmed number of ticks and stays high until the next restart. Every hand-over is green, then yellow for the short interval, then red. An all-red gap follows, which ends at the next tick. The pedestrian input is expected to be debounced already.

Top module: `hwy_side_signal_ctrl`

## Requirements
- R1: During and after reset, the highway shows green and the side road shows red.
- R2: While the side-road sensor is low and no pedestrian request is pending, the highway stays green indefinitely.
- R3: A side-road car ends the highway green only once the highway has been green for LONG_S ticks. With the sensor held, the highway green lasts between (LONG_S-1)*TICK_DIV+2 and LONG_S*TICK_DIV+1 clocks.
- R4: A road that loses the right of way goes from green to yellow to red. Each yellow lasts SHORT_S ticks, between (SHORT_S-1)*TICK_DIV+2 and SHORT_S*TICK_DIV+1 clocks.
- R5: Between a yellow and the other road's green, both roads show red for 1 to TICK_DIV clocks. This gap ends at the next tick.
- R6: The side-road green lasts at least MID_S ticks. If the sensor is low once MID_S ticks have passed, the side road goes to yellow.
- R7: While the sensor stays high, the side-road green extends, but it never lasts more than LONG_S ticks. With the sensor held, it lasts between (LONG_S-1)*TICK_DIV+2 and LONG_S*TICK_DIV+1 clocks.
- R8: A pedestrian request, even a single clock long, is latched and treated like a side-road car. The latch clears when the highway turns red. A request present in that same clock is kept, so it is served on the next cycle.
- R9: Exactly one lamp is lit on each road at all times, and the two roads are never both non-red.
- R10: One second is TICK_DIV clock cycles. All intervals scale with TICK_DIV.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| side_car_i | input | 1 | Side-road car sensor, high while a car is present |
| ped_req_i | input | 1 | Debounced pedestrian request to cross the highway |
| hwy_red_o | output | 1 | Highway red lamp |
| hwy_yel_o | output | 1 | Highway yellow lamp |
| hwy_grn_o | output | 1 | Highway green lamp |
| side_red_o | output | 1 | Side-road red lamp |
| side_yel_o | output | 1 | Side-road yellow lamp |
| side_grn_o | output | 1 | Side-road green lamp |

## Verification
Two functions can fall in the same clock: clearing the pedestrian latch as the highway turns red, and capturing a new request. The bench holds the request high across the whole highway yellow and the red transition. It then expects another full side-road phase about one minimum highway green later, with no car present. A second coincidence is the sensor dropping after the medium minimum while the long timer is still running. The bench judges both by comparing the lamps every clock against its own behavioural model, and by checking the measured phase lengths against the R3, R6 and R7 clock windows.

// File: rtl/tlc_pkg.sv
package tlc_pkg;
   typedef enum logic [2:0] {
      PH_HWY_GO        = 3'd0,
      PH_HWY_WARN      = 3'd1,
      PH_CLEAR_TO_SIDE = 3'd2,
      PH_SIDE_GO       = 3'd3,
      PH_SIDE_WARN     = 3'd4,
      PH_CLEAR_TO_HWY  = 3'd5
   } phase_e;

   typedef struct packed {
      logic red;
      logic yel;
      logic grn;
   } lamp_s;

   localparam int TMR_LONG  = 0;
   localparam int TMR_MID   = 1;
   localparam int TMR_SHORT = 2;
   localparam int NUM_TMR   = 3;
endpackage

// File: rtl/tlc_tick_gen.sv
module tlc_tick_gen #(
   parameter int TICK_DIV = 50_000_000
) (
   input  logic clk,
   input  logic rst_n,
   output logic tick_o
);
   generate
      if (TICK_DIV == 1) begin : g_every_clk
         logic tick_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) tick_q <= 1'b0;
            else        tick_q <= 1'b1;
         end
         assign tick_o = tick_q;
      end else begin : g_divider
         localparam int CW = $clog2(TICK_DIV);
         logic [CW-1:0] cnt_q;
         assign tick_o = (cnt_q == CW'(TICK_DIV - 1));
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      cnt_q <= '0;
            else if (tick_o) cnt_q <= '0;
            else             cnt_q <= cnt_q + 1'b1;
         end
      end
   endgenerate
endmodule

// File: rtl/tlc_interval_timer.sv
module tlc_interval_timer #(
   parameter int PERIOD = 10
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick_i,
   input  logic trig_i,
   output logic done_o
);
   localparam int CW = $clog2(PERIOD + 1);

   logic [CW-1:0] cnt_q;
   logic          done_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         done_q <= 1'b0;
      end else if (trig_i) begin
         cnt_q  <= '0;
         done_q <= 1'b0;
      end else if (tick_i && !done_q) begin
         cnt_q <= cnt_q + 1'b1;
         if (cnt_q == CW'(PERIOD - 1)) done_q <= 1'b1;
      end
   end

   assign done_o = done_q;
endmodule

// File: rtl/tlc_phase_fsm.sv
module tlc_phase_fsm
   import tlc_pkg::*;
(
   input  logic               clk,
   input  logic               rst_n,
   input  logic               tick_i,
   input  logic               side_car_i,
   input  logic               ped_req_i,
   input  logic [NUM_TMR-1:0] done_i,
   output logic [NUM_TMR-1:0] trig_o,
   output logic               pend_o,
   output lamp_s              hwy_lamp_o,
   output lamp_s              side_lamp_o
);
   phase_e state_q, state_d;
   logic   pend_q, clr_pend;

   always_comb begin
      state_d  = state_q;
      trig_o   = '0;
      clr_pend = 1'b0;
      case (state_q)
         PH_HWY_GO: if (done_i[TMR_LONG] && (side_car_i || pend_q)) begin
            state_d           = PH_HWY_WARN;
            trig_o[TMR_SHORT] = 1'b1;
         end
         PH_HWY_WARN: if (done_i[TMR_SHORT]) begin
            state_d  = PH_CLEAR_TO_SIDE;
            clr_pend = 1'b1;
         end
         PH_CLEAR_TO_SIDE: if (tick_i) begin
            state_d          = PH_SIDE_GO;
            trig_o[TMR_MID]  = 1'b1;
            trig_o[TMR_LONG] = 1'b1;
         end
         PH_SIDE_GO: if (done_i[TMR_LONG] || (done_i[TMR_MID] && !side_car_i)) begin
            state_d           = PH_SIDE_WARN;
            trig_o[TMR_SHORT] = 1'b1;
         end
         PH_SIDE_WARN: if (done_i[TMR_SHORT]) state_d = PH_CLEAR_TO_HWY;
         PH_CLEAR_TO_HWY: if (tick_i) begin
            state_d          = PH_HWY_GO;
            trig_o[TMR_LONG] = 1'b1;
         end
         default: state_d = PH_HWY_GO;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= PH_HWY_GO;
         pend_q  <= 1'b0;
      end else begin
         state_q <= state_d;
         pend_q  <= (pend_q && !clr_pend) || ped_req_i;
      end
   end

   assign pend_o = pend_q;

   always_comb begin
      hwy_lamp_o  = '{red: 1'b1, yel: 1'b0, grn: 1'b0};
      side_lamp_o = '{red: 1'b1, yel: 1'b0, grn: 1'b0};
      case (state_q)
         PH_HWY_GO:    hwy_lamp_o  = '{red: 1'b0, yel: 1'b0, grn: 1'b1};
         PH_HWY_WARN:  hwy_lamp_o  = '{red: 1'b0, yel: 1'b1, grn: 1'b0};
         PH_SIDE_GO:   side_lamp_o = '{red: 1'b0, yel: 1'b0, grn: 1'b1};
         PH_SIDE_WARN: side_lamp_o = '{red: 1'b0, yel: 1'b1, grn: 1'b0};
         default: ;
      endcase
   end
endmodule

// File: rtl/hwy_side_signal_ctrl.sv
module hwy_side_signal_ctrl
   import tlc_pkg::*;
#(
   parameter int TICK_DIV = 50_000_000,
   parameter int LONG_S   = 60,
   parameter int MID_S    = 30,
   parameter int SHORT_S  = 10
) (
   input  logic clk,
   input  logic rst_n,
   input  logic side_car_i,
   input  logic ped_req_i,
   output logic hwy_red_o,
   output logic hwy_yel_o,
   output logic hwy_grn_o,
   output logic side_red_o,
   output logic side_yel_o,
   output logic side_grn_o
);
   generate
      if (TICK_DIV < 1) begin : g_bad_div
         $fatal(1, "TICK_DIV must be at least 1");
      end
      if (SHORT_S < 1 || MID_S < 1) begin : g_bad_short
         $fatal(1, "interval lengths must be at least 1 tick");
      end
      if (MID_S > LONG_S) begin : g_bad_order
         $fatal(1, "MID_S must not exceed LONG_S");
      end
   endgenerate

   function automatic int period_of(input int idx);
      case (idx)
         TMR_LONG: return LONG_S;
         TMR_MID:  return MID_S;
         default:  return SHORT_S;
      endcase
   endfunction

   logic               tick;
   logic               ped_pend;
   logic [NUM_TMR-1:0] tmr_trig, tmr_done;
   lamp_s              hwy_lamp, side_lamp;

   tlc_tick_gen #(.TICK_DIV(TICK_DIV)) u_tick (
      .clk    (clk),
      .rst_n  (rst_n),
      .tick_o (tick)
   );

   for (genvar gi = 0; gi < NUM_TMR; gi++) begin : g_tmr
      tlc_interval_timer #(.PERIOD(period_of(gi))) u_tmr (
         .clk    (clk),
         .rst_n  (rst_n),
         .tick_i (tick),
         .trig_i (tmr_trig[gi]),
         .done_o (tmr_done[gi])
      );
   end

   tlc_phase_fsm u_fsm (
      .clk         (clk),
      .rst_n       (rst_n),
      .tick_i      (tick),
      .side_car_i  (side_car_i),
      .ped_req_i   (ped_req_i),
      .done_i      (tmr_done),
      .trig_o      (tmr_trig),
      .pend_o      (ped_pend),
      .hwy_lamp_o  (hwy_lamp),
      .side_lamp_o (side_lamp)
   );

   assign hwy_red_o  = hwy_lamp.red;
   assign hwy_yel_o  = hwy_lamp.yel;
   assign hwy_grn_o  = hwy_lamp.grn;
   assign side_red_o = side_lamp.red;
   assign side_yel_o = side_lamp.yel;
   assign side_grn_o = side_lamp.grn;
endmodule

// File: rtl/tlc_ctrl_checker.sv
module tlc_ctrl_checker #(
   parameter int LONG_S = 60,
   parameter int MID_S  = 30
) (
   input logic clk,
   input logic rst_n,
   input logic tick,
   input logic side_car,
   input logic ped_pend,
   input logic hwy_red,
   input logic hwy_yel,
   input logic hwy_grn,
   input logic side_red,
   input logic side_yel,
   input logic side_grn
);
   localparam int CW = $clog2(LONG_S + 2);

   logic [CW-1:0] hg_ticks, sg_ticks;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hg_ticks <= '0;
         sg_ticks <= '0;
      end else begin
         if (!hwy_grn)                                   hg_ticks <= '0;
         else if (tick && hg_ticks != CW'(LONG_S + 1))   hg_ticks <= hg_ticks + 1'b1;
         if (!side_grn)                                  sg_ticks <= '0;
         else if (tick && sg_ticks != CW'(LONG_S + 1))   sg_ticks <= sg_ticks + 1'b1;
      end
   end

   assert_lamp_onehot_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $countones({hwy_red, hwy_yel, hwy_grn}) == 1 && $countones({side_red, side_yel, side_grn}) == 1);

   assert_no_conflict_R9: assert property (@(posedge clk) disable iff (!rst_n)
      hwy_red || side_red);

   assert_hwy_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (hwy_grn && !side_car && !ped_pend) |=> hwy_grn);

   assert_hwy_min_green_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(hwy_grn) |-> hg_ticks >= CW'(LONG_S));

   assert_hwy_grn_to_yel_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(hwy_grn) |-> hwy_yel);

   assert_side_grn_to_yel_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(side_grn) |-> side_yel);

   assert_yel_to_red_R4: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(hwy_yel) |-> hwy_red) and ($fell(side_yel) |-> side_red));

   assert_all_red_gap_R5: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(side_grn) || $rose(hwy_grn)) |-> ($past(hwy_red) && $past(side_red)));

   assert_side_min_green_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(side_grn) |-> sg_ticks >= CW'(MID_S));

   assert_side_max_green_R7: assert property (@(posedge clk) disable iff (!rst_n)
      sg_ticks <= CW'(LONG_S));
endmodule

bind hwy_side_signal_ctrl tlc_ctrl_checker #(.LONG_S(LONG_S), .MID_S(MID_S)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .tick     (tick),
   .side_car (side_car_i),
   .ped_pend (ped_pend),
   .hwy_red  (hwy_red_o),
   .hwy_yel  (hwy_yel_o),
   .hwy_grn  (hwy_grn_o),
   .side_red (side_red_o),
   .side_yel (side_yel_o),
   .side_grn (side_grn_o)
);

// File: tb/hwy_side_signal_ctrl_tb_top.sv
module hwy_side_signal_ctrl_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int DIV        = 4;
   localparam int LONG_S     = 60;
   localparam int MID_S      = 30;
   localparam int SHORT_S    = 10;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic side_car = 1'b0;
   logic ped_req = 1'b0;
   logic hwy_red, hwy_yel, hwy_grn, side_red, side_yel, side_grn;

   always #(CLK_PERIOD / 2) clk = ~clk;

   hwy_side_signal_ctrl #(
      .TICK_DIV (DIV), .LONG_S (LONG_S), .MID_S (MID_S), .SHORT_S (SHORT_S)
   ) dut_i (
      .clk (clk), .rst_n (rst_n), .side_car_i (side_car), .ped_req_i (ped_req),
      .hwy_red_o (hwy_red), .hwy_yel_o (hwy_yel), .hwy_grn_o (hwy_grn),
      .side_red_o (side_red), .side_yel_o (side_yel), .side_grn_o (side_grn)
   );

   int    n_checks = 0;
   int    n_fail   = 0;
   bit    finished = 1'b0;
   string cur_req  = "R1";

   task automatic check(input string req, input bit ok, input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic wrap_up();
      if (!finished) begin
         finished = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   endtask

   // Behavioural reference: phase 0 hwy green, 1 hwy yellow, 2 all red before side,
   // 3 side green, 4 side yellow, 5 all red before highway.
   int m_sec;
   int m_ph;
   int m_pend;
   int m_el [3];
   bit m_up [3];
   int m_len [3] = '{LONG_S, MID_S, SHORT_S};

   always @(posedge clk) begin
      if (!rst_n) begin
         m_sec = 0; m_ph = 0; m_pend = 0;
         foreach (m_el[i]) begin m_el[i] = 0; m_up[i] = 1'b0; end
      end else begin
         bit tk;
         int nph;
         bit rs [3];
         bit leave_hwy;
         tk = (m_sec == DIV - 1);
         nph = m_ph;
         rs = '{1'b0, 1'b0, 1'b0};
         leave_hwy = 1'b0;
         if (m_ph == 0 && m_up[0] && (side_car || m_pend != 0)) begin nph = 1; rs[2] = 1'b1; end
         else if (m_ph == 1 && m_up[2]) begin nph = 2; leave_hwy = 1'b1; end
         else if (m_ph == 2 && tk) begin nph = 3; rs[0] = 1'b1; rs[1] = 1'b1; end
         else if (m_ph == 3 && (m_up[0] || (m_up[1] && !side_car))) begin nph = 4; rs[2] = 1'b1; end
         else if (m_ph == 4 && m_up[2]) nph = 5;
         else if (m_ph == 5 && tk) begin nph = 0; rs[0] = 1'b1; end
         for (int i = 0; i < 3; i++) begin
            if (rs[i]) begin m_el[i] = 0; m_up[i] = 1'b0; end
            else if (tk && !m_up[i]) begin
               m_el[i]++;
               if (m_el[i] == m_len[i]) m_up[i] = 1'b1;
            end
         end
         m_pend = ((m_pend != 0 && !leave_hwy) || ped_req) ? 1 : 0;
         m_sec = tk ? 0 : m_sec + 1;
         m_ph = nph;
      end
   end

   always @(negedge clk) begin
      if (rst_n && !finished) begin
         int exp_h, exp_s, act_h, act_s;
         exp_h = (m_ph == 0) ? 1 : (m_ph == 1) ? 2 : 4;
         exp_s = (m_ph == 3) ? 1 : (m_ph == 4) ? 2 : 4;
         act_h = {29'd0, hwy_red, hwy_yel, hwy_grn};
         act_s = {29'd0, side_red, side_yel, side_grn};
         check({cur_req, " lamps vs model (hwy)"}, act_h == exp_h, act_h, exp_h);
         check({cur_req, " lamps vs model (side)"}, act_s == exp_s, act_s, exp_s);
         check("R9 one lamp per road, no conflict",
               $countones(act_h) == 1 && $countones(act_s) == 1 && (hwy_red || side_red),
               act_h * 16 + act_s, 0);
      end
   end

   function automatic bit lamp(input int which);
      case (which)
         0: return hwy_grn;
         1: return hwy_yel;
         2: return side_grn;
         3: return side_yel;
         default: return hwy_red && side_red;
      endcase
   endfunction

   task automatic measure(input int which, output int n);
      n = 0;
      while (lamp(which) && n < 5000) begin n++; @(negedge clk); end
   endtask

   task automatic wait_for(input int which);
      int guard = 0;
      while (!lamp(which) && guard < 5000) begin guard++; @(negedge clk); end
   endtask

   task automatic check_window(input string req, input int n, input int secs);
      int lo, hi;
      lo = (secs - 1) * DIV + 2;
      hi = secs * DIV + 1;
      check(req, n >= lo && n <= hi, n, hi);
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      wrap_up();
   end

   initial begin
      int n;
      bit held;
      // R1: reset state
      repeat (3) @(negedge clk);
      check("R1 hwy green in reset", hwy_grn && !hwy_yel && !hwy_red, {31'd0, hwy_grn}, 1);
      check("R1 side red in reset", side_red && !side_grn && !side_yel, {31'd0, side_red}, 1);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 hwy green after reset", hwy_grn == 1'b1, {31'd0, hwy_grn}, 1);

      // R2: no demand, highway keeps green well past the long interval
      cur_req = "R2";
      held = 1'b1;
      for (int c = 0; c < 80 * DIV; c++) begin
         held = held && hwy_grn;
         @(negedge clk);
      end
      check("R2 hwy held green with no demand", held, {31'd0, held}, 1);

      // R3/R4/R5/R7: car held, highway minimum already met
      cur_req = "R3";
      side_car = 1'b1;
      @(negedge clk);
      @(negedge clk);
      check("R3 hwy yields after minimum met", hwy_yel == 1'b1, {31'd0, hwy_yel}, 1);
      cur_req = "R4";
      measure(1, n);
      check_window("R4 R10 hwy yellow length", n, SHORT_S);
      cur_req = "R5";
      measure(4, n);
      check("R5 all-red gap before side", n >= 1 && n <= DIV, n, DIV);
      cur_req = "R7";
      measure(2, n);
      check_window("R7 side green capped at long interval", n, LONG_S);
      cur_req = "R4";
      measure(3, n);
      check_window("R4 side yellow length", n, SHORT_S);
      cur_req = "R5";
      measure(4, n);
      check("R5 all-red gap before hwy", n >= 1 && n <= DIV, n, DIV);
      cur_req = "R3";
      measure(0, n);
      check_window("R3 hwy minimum green with car held", n, LONG_S);

      // R6: sensor drops at start of side green
      cur_req = "R6";
      wait_for(2);
      side_car = 1'b0;
      measure(2, n);
      check_window("R6 side green minimum length", n, MID_S);
      wait_for(0);
      cur_req = "R2";
      held = 1'b1;
      for (int c = 0; c < 100 * DIV; c++) begin
         held = held && hwy_grn;
         @(negedge clk);
      end
      check("R2 hwy stays green after side phase", held, {31'd0, held}, 1);

      // R8: single-clock pedestrian pulse
      cur_req = "R8";
      ped_req = 1'b1;
      @(negedge clk);
      ped_req = 1'b0;
      @(negedge clk);
      check("R8 pulse latched and served", hwy_yel == 1'b1, {31'd0, hwy_yel}, 1);
      wait_for(2);
      measure(2, n);
      check_window("R8 R6 ped-served side green", n, MID_S);
      wait_for(0);
      held = 1'b1;
      for (int c = 0; c < 100 * DIV; c++) begin
         held = held && hwy_grn;
         @(negedge clk);
      end
      check("R8 latch cleared after service", held, {31'd0, held}, 1);

      // R8: request present in the clock the highway turns red is kept
      side_car = 1'b1;
      @(negedge clk);
      wait_for(1);
      ped_req = 1'b1;
      wait_for(4);
      ped_req = 1'b0;
      side_car = 1'b0;
      wait_for(0);
      measure(0, n);
      check_window("R8 request kept across clear, served next cycle", n, LONG_S);
      wait_for(2);
      measure(2, n);
      check_window("R8 R6 second side green", n, MID_S);
      repeat (20) @(negedge clk);
      wrap_up();
   end
endmodule